// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Load/Store Unit

This block sits between a 32-bit register datapath and a data memory organised as 32-bit words with per-byte write enables. For each request it does the following:

- It forms the effective address from a base register and a signed 16-bit offset.
- It turns a byte, halfword or word access into a word address, a lane mask and steered write data.
- For loads, it picks the addressed lanes out of the returned word and extends them to 32 bits.

A mode input chooses, at run time, whether the lowest byte address of a word maps to the most significant lane (big-endian) or the least significant lane (little-endian).

The whole path is combinational. The caller presents one request at a time. A store is committed by the memory on its own clock edge whenever the write strobe is high. Misaligned halfword and word accesses are flagged, not trapped. Such an access neither writes memory nor returns data.

Operation code `op_i`: bits [3:2] give the kind and bits [1:0] give the size.

| Field | Value | Meaning |
|---|---|---|
| kind `op_i[3:2]` | 00 | idle |
| | 01 | signed load |
| | 10 | unsigned load |
| | 11 | store |
| size `op_i[1:0]` | 00 | byte |
| | 01 | halfword |
| | 10 | word |
| | 11 | reserved |

Memory lane L is `mem_wdata_o/mem_rdata_i[8L+7:8L]`, enabled by `mem_be_o[L]`.

Top module: `byte_lsu`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits. `mem_addr_o` carries its bits [31:2]. The low two bits are the byte offset k within the word.
- R2: A word access (size 10) touches all lanes. A store drives `mem_we_o`=1, `mem_be_o`=4'b1111 and `mem_wdata_o`=`store_data_i`. A word load returns `mem_rdata_i` unchanged. Both hold in either mode.
- R3: Byte offset k maps to lane k when `big_endian_i`=0, and to lane 3-k when `big_endian_i`=1. A byte access drives `mem_be_o` one-hot on that lane, for loads and for stores. A byte store replicates `store_data_i[7:0]` on every lane.
- R4: A halfword at offset 2h uses lane pair h (lanes 2h+1:2h) in little-endian mode and pair 1-h in big-endian mode. In both modes the upper lane of the pair holds the more significant byte. `mem_be_o` is 4'b0011 or 4'b1100. A halfword store replicates `store_data_i[15:0]` in both halves.
- R5: Signed byte and halfword loads (kind 01) sign-extend the selected data to 32 bits.
- R6: Unsigned byte and halfword loads (kind 10) zero-extend the selected data to 32 bits.
- R7: A halfword access with address bit 0 set, or a word access with either of address bits [1:0] set, raises `misalign_o`. It drives `mem_we_o`=0 and `mem_be_o`=0, and returns `load_data_o`=0. Byte accesses are never misaligned.
- R8: An idle kind (00) or the reserved size (11) gives `mem_we_o`=0, `mem_be_o`=0, `misalign_o`=0 and `load_data_o`=0.
- R9: A stored word reads back bytewise in mode order. After a word store of 0x00000005 at address 8, byte loads at 8 and 11 return 0 and 5 in big-endian mode, and 5 and 0 in little-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| op_i | input | 4 | Kind [3:2] and size [1:0] of the request |
| store_data_i | input | 32 | Register value to store |
| big_endian_i | input | 1 | 1 selects big-endian lane mapping, 0 selects little-endian |
| mem_rdata_i | input | 32 | Word read from memory at `mem_addr_o` |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Lanes touched by the access |
| mem_we_o | output | 1 | Write strobe for the enabled lanes |
| mem_wdata_o | output | 32 | Steered store data |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Alignment fault on the current request |

## Verification
A store request and an alignment fault can arrive in the same cycle. In that cycle the fault must override the write. The bench provokes this with a halfword store to an odd address and a word store to an address with offset 2, both aimed at a word that already holds a known pattern. It judges the result by the flag being high, the strobe and lane mask being low, and the word reading back unchanged after the memory clock edge. Misaligned loads are checked the same way, and the bench expects a zero result from them.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      KIND_IDLE = 2'b00,
      KIND_LDS  = 2'b01,
      KIND_LDU  = 2'b10,
      KIND_ST   = 2'b11
   } lsu_kind_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } lsu_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IMM_W-1:0]  offset_i,
   input  logic              active_i,
   input  lsu_size_e         size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              fault_o
);
   localparam int EXT_W = ADDR_W - IMM_W;

   generate
      if (IMM_W >= ADDR_W) begin : g_bad_imm
         $error("lsu_agen: IMM_W must be narrower than ADDR_W");
      end
   endgenerate

   assign ea_o = base_i + {{EXT_W{offset_i[IMM_W-1]}}, offset_i};

   always_comb begin
      fault_o = 1'b0;
      if (active_i) begin
         case (size_i)
            SZ_HALF: fault_o = ea_o[0];
            SZ_WORD: fault_o = |ea_o[1:0];
            default: fault_o = 1'b0;
         endcase
      end
   end

   always_comb begin
      if (active_i && size_i == SZ_BYTE) begin
         AST_BYTE_NEVER_FAULTS: assert (!fault_o); // R7
      end
   end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              active_i,
   input  logic              store_i,
   input  logic              fault_i,
   input  lsu_size_e         size_i,
   input  logic [1:0]        lane_off_i,
   input  logic              big_endian_i,
   input  logic [DATA_W-1:0] store_data_i,
   output logic [DATA_W/8-1:0] be_o,
   output logic              we_o,
   output logic [DATA_W-1:0] wdata_o
);
   localparam int LANES = DATA_W / 8;

   logic [1:0] flip;
   logic [1:0] byte_lane;
   logic       half_pair;
   logic       go;

   assign flip      = big_endian_i ? 2'b11 : 2'b00;
   assign byte_lane = lane_off_i ^ flip;
   assign half_pair = lane_off_i[1] ^ big_endian_i;
   assign go        = active_i && !fault_i;
   assign we_o      = go && store_i;

   always_comb begin
      be_o = '0;
      if (go) begin
         case (size_i)
            SZ_BYTE: be_o = 4'b0001 << byte_lane;
            SZ_HALF: be_o = half_pair ? 4'b1100 : 4'b0011;
            SZ_WORD: be_o = 4'b1111;
            default: be_o = '0;
         endcase
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] lane_w;
         always_comb begin
            case (size_i)
               SZ_BYTE: lane_w = store_data_i[7:0];
               SZ_HALF: lane_w = store_data_i[8*(l%2) +: 8];
               default: lane_w = store_data_i[8*l +: 8];
            endcase
         end
         assign wdata_o[8*l +: 8] = lane_w;
      end
   endgenerate

   always_comb begin
      if (we_o && size_i == SZ_BYTE) begin
         AST_BYTE_ONEHOT: assert ($onehot(be_o)); // R3
      end
      if (we_o && size_i == SZ_HALF) begin
         AST_HALF_PAIR: assert (be_o == 4'b0011 || be_o == 4'b1100); // R4
      end
      if (we_o && size_i == SZ_WORD) begin
         AST_WORD_ALL_LANES: assert (be_o == 4'b1111); // R2
      end
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              load_i,
   input  logic              unsigned_i,
   input  logic              fault_i,
   input  lsu_size_e         size_i,
   input  logic [1:0]        lane_off_i,
   input  logic              big_endian_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] load_data_o
);
   localparam int LANES = DATA_W / 8;

   logic [7:0]  lane_b [LANES];
   logic [7:0]  byte_sel;
   logic [15:0] half_sel;
   logic [1:0]  byte_lane;
   logic        half_pair;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_split
         assign lane_b[l] = rdata_i[8*l +: 8];
      end
   endgenerate

   assign byte_lane = lane_off_i ^ {big_endian_i, big_endian_i};
   assign half_pair = lane_off_i[1] ^ big_endian_i;
   assign byte_sel  = lane_b[byte_lane];
   assign half_sel  = half_pair ? rdata_i[31:16] : rdata_i[15:0];

   always_comb begin
      load_data_o = '0;
      if (load_i && !fault_i) begin
         case (size_i)
            SZ_BYTE: load_data_o = {{24{!unsigned_i & byte_sel[7]}}, byte_sel};
            SZ_HALF: load_data_o = {{16{!unsigned_i & half_sel[15]}}, half_sel};
            SZ_WORD: load_data_o = rdata_i;
            default: load_data_o = '0;
         endcase
      end
   end

   always_comb begin
      if (load_i && !fault_i && unsigned_i && size_i == SZ_BYTE) begin
         AST_UBYTE_ZERO_TOP: assert (load_data_o[31:8] == 24'h0); // R6
      end
      if (load_i && !fault_i && !unsigned_i && size_i == SZ_HALF) begin
         AST_SHALF_SIGN_TOP: assert (load_data_o[31:16] == {16{load_data_o[15]}}); // R5
      end
   end
endmodule

// File: rtl/byte_lsu.sv
module byte_lsu
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [IMM_W-1:0]    offset_i,
   input  logic [3:0]          op_i,
   input  logic [DATA_W-1:0]   store_data_i,
   input  logic                big_endian_i,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic [ADDR_W-3:0]   mem_addr_o,
   output logic [DATA_W/8-1:0] mem_be_o,
   output logic                mem_we_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   output logic [DATA_W-1:0]   load_data_o,
   output logic                misalign_o
);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("byte_lsu: DATA_W must be 32");
      end
      if (LANES != 4) begin : g_bad_lanes
         $error("byte_lsu: four byte lanes expected");
      end
   endgenerate

   lsu_kind_e         kind;
   lsu_size_e         size;
   logic              active;
   logic [ADDR_W-1:0] ea;

   assign kind   = lsu_kind_e'(op_i[3:2]);
   assign size   = lsu_size_e'(op_i[1:0]);
   assign active = (kind != KIND_IDLE) && (size != SZ_RSVD);

   lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
      .base_i   (base_i),
      .offset_i (offset_i),
      .active_i (active),
      .size_i   (size),
      .ea_o     (ea),
      .fault_o  (misalign_o)
   );

   lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
      .active_i     (active),
      .store_i      (kind == KIND_ST),
      .fault_i      (misalign_o),
      .size_i       (size),
      .lane_off_i   (ea[1:0]),
      .big_endian_i (big_endian_i),
      .store_data_i (store_data_i),
      .be_o         (mem_be_o),
      .we_o         (mem_we_o),
      .wdata_o      (mem_wdata_o)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) u_load (
      .load_i       (active && (kind == KIND_LDS || kind == KIND_LDU)),
      .unsigned_i   (kind == KIND_LDU),
      .fault_i      (misalign_o),
      .size_i       (size),
      .lane_off_i   (ea[1:0]),
      .big_endian_i (big_endian_i),
      .rdata_i      (mem_rdata_i),
      .load_data_o  (load_data_o)
   );

   assign mem_addr_o = ea[ADDR_W-1:2];

   always_comb begin
      if (misalign_o) begin
         AST_FAULT_BLOCKS_WRITE: assert (!mem_we_o && mem_be_o == '0); // R7
         AST_FAULT_ZERO_LOAD: assert (load_data_o == '0); // R7
      end
      if (!active) begin
         AST_IDLE_QUIET: assert (!mem_we_o && mem_be_o == '0 && !misalign_o); // R8
      end
   end
endmodule

// File: tb/test_byte_lsu.sv
module test_byte_lsu;
   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] K_IDLE = 2'b00, K_LDS = 2'b01, K_LDU = 2'b10, K_ST = 2'b11;
   localparam logic [1:0] S_B = 2'b00, S_H = 2'b01, S_W = 2'b10, S_R = 2'b11;

   logic        clk = 1'b0;
   logic [31:0] base = '0;
   logic [15:0] offset = '0;
   logic [3:0]  op = 4'b0000;
   logic [31:0] sdata = '0;
   logic        bige = 1'b0;
   logic [31:0] rdata;
   logic [29:0] maddr;
   logic [3:0]  be;
   logic        we;
   logic [31:0] wdata;
   logic [31:0] ldata;
   logic        fault;

   logic [31:0] mem [16];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_lsu i_byte_lsu (
      .base_i(base), .offset_i(offset), .op_i(op), .store_data_i(sdata),
      .big_endian_i(bige), .mem_rdata_i(rdata), .mem_addr_o(maddr),
      .mem_be_o(be), .mem_we_o(we), .mem_wdata_o(wdata),
      .load_data_o(ldata), .misalign_o(fault)
   );

   assign rdata = mem[maddr[3:0]];

   always @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < 4; l++) begin
            if (be[l]) mem[maddr[3:0]][8*l +: 8] <= wdata[8*l +: 8];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] k, input logic [1:0] s, input logic [31:0] a,
                        input logic [31:0] d, input logic m);
      @(negedge clk);
      op = {k, s}; base = a; offset = 16'h0; sdata = d; bige = m;
      #1;
   endtask

   task automatic commit();
      @(posedge clk);
      #1;
      op = 4'b0000;
   endtask

   task automatic store(input logic [1:0] s, input logic [31:0] a, input logic [31:0] d, input logic m);
      drive(K_ST, s, a, d, m);
      commit();
   endtask

   task automatic load(input logic [1:0] k, input logic [1:0] s, input logic [31:0] a,
                       input logic m, output logic [31:0] v);
      drive(k, s, a, 32'h0, m);
      v = ldata;
      @(negedge clk);
      op = 4'b0000;
   endtask

   task automatic t_reset_state();
      drive(K_IDLE, S_W, 32'h4, 32'hFFFF_FFFF, 1'b0);
      chk("R8 idle we", {31'h0, we}, 32'h0);
      chk("R8 idle be", {28'h0, be}, 32'h0);
      chk("R8 idle load", ldata, 32'h0);
      chk("R8 idle fault", {31'h0, fault}, 32'h0);
      commit();
   endtask

   task automatic t_address();
      @(negedge clk);
      op = {K_LDS, S_B}; base = 32'h100; offset = 16'hFFFC; #1;
      chk("R1 negative offset", {2'b00, maddr}, 32'h3F);
      base = 32'h10; offset = 16'h7FFF; #1;
      chk("R1 positive offset", {2'b00, maddr}, 32'h2003);
      @(negedge clk);
      op = 4'b0000; offset = 16'h0;
   endtask

   task automatic t_word();
      logic [31:0] v;
      drive(K_ST, S_W, 32'h0, 32'h1234_5678, 1'b1);
      chk("R2 word be", {28'h0, be}, 32'hF);
      chk("R2 word wdata", wdata, 32'h1234_5678);
      commit();
      chk("R2 word memory", mem[0], 32'h1234_5678);
      load(K_LDS, S_W, 32'h0, 1'b0, v);
      chk("R2 word load little", v, 32'h1234_5678);
   endtask

   task automatic t_bytes_both_modes();
      logic [31:0] v;
      logic [7:0] be_bytes [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
      for (int k = 0; k < 4; k++) begin
         load(K_LDU, S_B, k, 1'b1, v);
         chk("R3 big-endian byte", v, {24'h0, be_bytes[k]});
         load(K_LDU, S_B, k, 1'b0, v);
         chk("R3 little-endian byte", v, {24'h0, be_bytes[3-k]});
      end
      load(K_LDU, S_H, 32'h0, 1'b1, v); chk("R4 big half 0", v, 32'h1234);
      load(K_LDU, S_H, 32'h2, 1'b1, v); chk("R4 big half 2", v, 32'h5678);
      load(K_LDU, S_H, 32'h0, 1'b0, v); chk("R4 little half 0", v, 32'h5678);
      load(K_LDU, S_H, 32'h2, 1'b0, v); chk("R4 little half 2", v, 32'h1234);
   endtask

   task automatic t_byte_store();
      logic [31:0] v;
      mem[1] = 32'hAAAA_AAAA;
      drive(K_ST, S_B, 32'h6, 32'h0000_0005, 1'b1);
      chk("R3 big byte be", {28'h0, be}, 32'h2);
      chk("R3 byte replicate", wdata, 32'h0505_0505);
      commit();
      chk("R3 big byte memory", mem[1], 32'hAAAA_05AA);
      load(K_LDS, S_B, 32'h6, 1'b1, v);
      chk("R3 byte readback", v, 32'h5);
      drive(K_ST, S_B, 32'h6, 32'h0000_0005, 1'b0);
      chk("R3 little byte be", {28'h0, be}, 32'h4);
      commit();
      chk("R3 little byte memory", mem[1], 32'hAA05_05AA);
   endtask

   task automatic t_sign();
      logic [31:0] v;
      store(S_B, 32'h9, 32'hABCD_EFF0, 1'b0);
      load(K_LDS, S_B, 32'h9, 1'b0, v); chk("R5 signed byte", v, 32'hFFFF_FFF0);
      load(K_LDU, S_B, 32'h9, 1'b0, v); chk("R6 unsigned byte", v, 32'h0000_00F0);
      drive(K_ST, S_H, 32'hE, 32'h0000_8001, 1'b1);
      chk("R4 big half be", {28'h0, be}, 32'h3);
      chk("R4 half replicate", wdata, 32'h8001_8001);
      commit();
      load(K_LDS, S_H, 32'hE, 1'b1, v); chk("R5 signed half", v, 32'hFFFF_8001);
      load(K_LDU, S_H, 32'hE, 1'b1, v); chk("R6 unsigned half", v, 32'h0000_8001);
      load(K_LDU, S_B, 32'hE, 1'b1, v); chk("R4 big half upper byte", v, 32'h80);
   endtask

   task automatic t_misalign();
      logic [31:0] v;
      mem[4] = 32'hCAFE_BABE;
      drive(K_ST, S_H, 32'h11, 32'h1111_1111, 1'b0);
      chk("R7 half fault", {31'h0, fault}, 32'h1);
      chk("R7 half no we", {31'h0, we}, 32'h0);
      chk("R7 half no be", {28'h0, be}, 32'h0);
      commit();
      drive(K_ST, S_W, 32'h12, 32'h2222_2222, 1'b1);
      chk("R7 word fault", {31'h0, fault}, 32'h1);
      chk("R7 word no we", {31'h0, we}, 32'h0);
      commit();
      chk("R7 memory kept", mem[4], 32'hCAFE_BABE);
      load(K_LDS, S_W, 32'h12, 1'b0, v);
      chk("R7 misaligned load zero", v, 32'h0);
      drive(K_LDU, S_B, 32'h13, 32'h0, 1'b0);
      chk("R7 byte never faults", {31'h0, fault}, 32'h0);
      chk("R7 byte odd load", ldata, 32'hCA);
      commit();
   endtask

   task automatic t_reserved();
      mem[5] = 32'h0BAD_F00D;
      drive(K_ST, S_R, 32'h14, 32'h5555_5555, 1'b0);
      chk("R8 reserved no we", {31'h0, we}, 32'h0);
      chk("R8 reserved no fault", {31'h0, fault}, 32'h0);
      commit();
      chk("R8 reserved memory kept", mem[5], 32'h0BAD_F00D);
      drive(K_LDS, S_R, 32'h14, 32'h0, 1'b0);
      chk("R8 reserved load zero", ldata, 32'h0);
      commit();
   endtask

   task automatic t_roundtrip();
      logic [31:0] v;
      store(S_W, 32'h8, 32'h0000_0005, 1'b1);
      load(K_LDS, S_B, 32'h8, 1'b1, v);  chk("R9 big addr 8", v, 32'h0);
      load(K_LDS, S_B, 32'hB, 1'b1, v);  chk("R9 big addr 11", v, 32'h5);
      store(S_W, 32'h8, 32'h0000_0005, 1'b0);
      load(K_LDS, S_B, 32'h8, 1'b0, v);  chk("R9 little addr 8", v, 32'h5);
      load(K_LDS, S_B, 32'hB, 1'b0, v);  chk("R9 little addr 11", v, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (2) @(posedge clk);
      t_reset_state();
      t_address();
      t_word();
      t_bytes_both_modes();
      t_byte_store();
      t_sign();
      t_misalign();
      t_reserved();
      t_roundtrip();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule